// File: doc/BRIEF.md
# Uniform-Symmetric Local Binary Pattern Bin Encoder

This block classifies one 8-bit local binary pattern per clock. It counts how often the code changes value around its circle, counts its one bits and derives a symmetry level. From these it assigns the code to one of 30 histogram bins, carried as a 5-bit index that loses nothing the later matching stage needs. The same index is expanded into a 30-bit one-hot occurrence vector, which is the per-pixel slice of the binary occurrence maps used for face matching.

A programmable matcher runs next to the classifier. Each code bit is marked, through a care mask and a wanted-value mask, as required one, required zero or don't care. Every result is registered and appears one cycle after the code is accepted. A two-state controller tracks whether the outputs hold a fresh result. `ST_IDLE` means no result was taken in on the last edge. `ST_LOADED` means a code was taken in on the last edge. The controller moves to `ST_LOADED` on any edge where `code_valid` is high, and to `ST_IDLE` on any edge where it is low. Reset forces `ST_IDLE`.

Top module: `lbp_bin_encoder`

## Requirements
- R1: `trans_cnt` is the number of neighbouring bit pairs that differ, counted around the circle. Bit 7 and bit 0 count as neighbours, so the value is always even, from 0 to 8.
- R2: `uniform` is 1 exactly when `trans_cnt` is at most 2. For example, 8'hC3 and 8'h1C are uniform, and 8'h54 and 8'h6D are not.
- R3: `ones_cnt` is the number of one bits in the code. `sym_lvl` is the smaller of `ones_cnt` and 8 minus `ones_cnt`.
- R4: A uniform code with 3, 4 or 5 ones goes to bin 8*(ones-3)+p. Here p is the index of the one bit whose lower circular neighbour (bit p-1, with bit 7 below bit 0) is zero. This fills bins 0 to 23.
- R5: The other uniform codes go to fixed bins. Codes with 0 or 8 ones go to bin 24. Codes with 1 one go to 25, with 2 ones to 26, with 6 ones to 27 and with 7 ones to 28.
- R6: Every non-uniform code goes to bin 29.
- R7: While `out_valid` is 1, `occ_vec` has exactly one bit set, at position `bin_idx`. While `out_valid` is 0, `occ_vec` is all zeros.
- R8: Bits with care=1 and want=1 must be 1 in the code, or `match` is 0.
- R9: Bits with care=1 and want=0 must be 0 in the code, or `match` is 0. `match` is 1 when both checks pass, and `want` has no effect on bits with care=0.
- R10: The result for a code sampled with `code_valid` high appears on the next clock edge, with `out_valid` high for that one cycle. When `code_valid` is low, the outputs other than `out_valid` and `occ_vec` keep their values.
- R11: While `rst_n` is low, and right after reset, `out_valid`, `match`, `occ_vec` and all count and bin outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| code_valid | input | 1 | The code on `code` is taken in on this edge |
| code | input | 8 | Local binary pattern code |
| care_mask | input | 8 | Bits that take part in matching |
| want_mask | input | 8 | Required values of the cared bits |
| out_valid | output | 1 | The outputs hold a result taken in on the last edge |
| trans_cnt | output | 4 | Number of circular transitions |
| ones_cnt | output | 4 | Number of one bits |
| sym_lvl | output | 3 | Symmetry level |
| uniform | output | 1 | The code has at most two transitions |
| bin_idx | output | 5 | Bin index, 0 to 29 |
| match | output | 1 | The code satisfies the mask pattern |
| occ_vec | output | 30 | One-hot occurrence vector of `bin_idx` |

## Verification
The block's only state is the result register and the two-state controller, so every internal fault shows at the ports within one cycle. A wrong run-position or count shows up as a shifted `bin_idx` and `occ_vec` on the cycle after the code is accepted. A stuck controller shows as `out_valid` or `occ_vec` that fails to rise on that cycle or fails to fall on the next idle cycle. A sweep of all 256 codes tallies the bins: bins 0 to 23 must each receive exactly one code, bin 24 two codes, bins 25 to 28 eight codes each, and bin 29 the remaining 198. Any mapping fault therefore changes a count.

// File: rtl/lbp_bin_pkg.sv
package lbp_bin_pkg;
    localparam int CODE_W   = 8;
    localparam int CNT_W    = $clog2(CODE_W + 1);
    localparam int SYM_W    = $clog2(CODE_W / 2 + 1);
    localparam int POS_W    = $clog2(CODE_W);
    localparam int NUM_BINS = 30;
    localparam int BIN_W    = $clog2(NUM_BINS);

    localparam logic [BIN_W-1:0] BIN_FLAT  = BIN_W'(3 * CODE_W);
    localparam logic [BIN_W-1:0] BIN_ONE   = BIN_W'(3 * CODE_W + 1);
    localparam logic [BIN_W-1:0] BIN_TWO   = BIN_W'(3 * CODE_W + 2);
    localparam logic [BIN_W-1:0] BIN_SIX   = BIN_W'(3 * CODE_W + 3);
    localparam logic [BIN_W-1:0] BIN_SEVEN = BIN_W'(3 * CODE_W + 4);
    localparam logic [BIN_W-1:0] BIN_MIXED = BIN_W'(NUM_BINS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] trans;
        logic [CNT_W-1:0] ones;
        logic [SYM_W-1:0] sym;
        logic             uniform;
        logic [BIN_W-1:0] bin;
        logic             match;
    } lbp_result_t;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_LOADED = 1'b1
    } lbp_state_e;
endpackage

// File: rtl/lbp_code_stats.sv
module lbp_code_stats
    import lbp_bin_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  trans,
    output logic [CNT_W-1:0]  ones,
    output logic [SYM_W-1:0]  sym,
    output logic              uniform,
    output logic [POS_W-1:0]  run_pos
);
    logic [CODE_W-1:0] edge_bits;
    logic [CODE_W-1:0] run_head;
    logic [CNT_W-1:0]  zeros;

    // Each bit is compared with its circular neighbours.
    for (genvar i = 0; i < CODE_W; i++) begin : g_bit
        assign edge_bits[i] = code[i] ^ code[(i + 1) % CODE_W];
        assign run_head[i]  = code[i] & ~code[(i + CODE_W - 1) % CODE_W];
    end

    always_comb begin
        trans   = CNT_W'($countones(edge_bits));
        ones    = CNT_W'($countones(code));
        zeros   = CNT_W'(CODE_W) - ones;
        sym     = (ones < zeros) ? SYM_W'(ones) : SYM_W'(zeros);
        uniform = (trans <= CNT_W'(2));
        run_pos = '0;
        for (int i = 0; i < CODE_W; i++) begin
            if (run_head[i]) run_pos = POS_W'(i);
        end
    end
endmodule

// File: rtl/lbp_bin_map.sv
module lbp_bin_map
    import lbp_bin_pkg::*;
(
    input  logic             uniform,
    input  logic [CNT_W-1:0] ones,
    input  logic [POS_W-1:0] run_pos,
    output logic [BIN_W-1:0] bin
);
    localparam logic [BIN_W-1:0] STRIDE = BIN_W'(CODE_W);

    always_comb begin
        if (!uniform) begin
            bin = BIN_MIXED;
        end else begin
            case (ones)
                CNT_W'(1): bin = BIN_ONE;
                CNT_W'(2): bin = BIN_TWO;
                CNT_W'(3): bin = BIN_W'(run_pos);
                CNT_W'(4): bin = STRIDE + BIN_W'(run_pos);
                CNT_W'(5): bin = STRIDE + STRIDE + BIN_W'(run_pos);
                CNT_W'(6): bin = BIN_SIX;
                CNT_W'(7): bin = BIN_SEVEN;
                default:   bin = BIN_FLAT;
            endcase
        end
    end
endmodule

// File: rtl/lbp_pattern_match.sv
module lbp_pattern_match
    import lbp_bin_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic [CODE_W-1:0] care,
    input  logic [CODE_W-1:0] want,
    output logic              match
);
    logic [CODE_W-1:0] need_one;
    logic [CODE_W-1:0] need_zero;
    logic              ones_ok;
    logic              zeros_ok;

    always_comb begin
        need_one  = care & want;
        need_zero = care & ~want;
        ones_ok   = ((code & need_one) == need_one);
        zeros_ok  = ((~code & need_zero) == need_zero);
        match     = ones_ok & zeros_ok;
    end
endmodule

// File: rtl/lbp_bin_decode.sv
module lbp_bin_decode
    import lbp_bin_pkg::*;
(
    input  logic                en,
    input  logic [BIN_W-1:0]    bin,
    output logic [NUM_BINS-1:0] occ
);
    for (genvar b = 0; b < NUM_BINS; b++) begin : g_occ
        assign occ[b] = en && (bin == BIN_W'(b));
    end
endmodule

// File: rtl/lbp_bin_encoder.sv
module lbp_bin_encoder
    import lbp_bin_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                code_valid,
    input  logic [CODE_W-1:0]   code,
    input  logic [CODE_W-1:0]   care_mask,
    input  logic [CODE_W-1:0]   want_mask,
    output logic                out_valid,
    output logic [CNT_W-1:0]    trans_cnt,
    output logic [CNT_W-1:0]    ones_cnt,
    output logic [SYM_W-1:0]    sym_lvl,
    output logic                uniform,
    output logic [BIN_W-1:0]    bin_idx,
    output logic                match,
    output logic [NUM_BINS-1:0] occ_vec
);
    lbp_result_t      nxt_res;
    lbp_result_t      res_q;
    lbp_state_e       state_q;
    lbp_state_e       state_d;
    logic [POS_W-1:0] run_pos;

    lbp_code_stats u_stats (
        .code    (code),
        .trans   (nxt_res.trans),
        .ones    (nxt_res.ones),
        .sym     (nxt_res.sym),
        .uniform (nxt_res.uniform),
        .run_pos (run_pos)
    );

    lbp_bin_map u_map (
        .uniform (nxt_res.uniform),
        .ones    (nxt_res.ones),
        .run_pos (run_pos),
        .bin     (nxt_res.bin)
    );

    lbp_pattern_match u_match (
        .code  (code),
        .care  (care_mask),
        .want  (want_mask),
        .match (nxt_res.match)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = code_valid ? ST_LOADED : ST_IDLE;
            ST_LOADED: state_d = code_valid ? ST_LOADED : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            res_q   <= '0;
        end else begin
            state_q <= state_d;
            if (code_valid) res_q <= nxt_res;
        end
    end

    always_comb begin
        out_valid = (state_q == ST_LOADED);
        trans_cnt = res_q.trans;
        ones_cnt  = res_q.ones;
        sym_lvl   = res_q.sym;
        uniform   = res_q.uniform;
        bin_idx   = res_q.bin;
        match     = res_q.match;
    end

    lbp_bin_decode u_dec (
        .en  (out_valid),
        .bin (res_q.bin),
        .occ (occ_vec)
    );

    // R7
    valid_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(occ_vec) == 1 && occ_vec[bin_idx]));
    // R7
    idle_occ_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (occ_vec == '0));
    // R6
    mixed_bin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !uniform) |-> (bin_idx == BIN_MIXED));
    // R4
    run_bin_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && uniform && ones_cnt >= 3 && ones_cnt <= 5) |-> (bin_idx < BIN_FLAT));
    // R1
    trans_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (trans_cnt[0] == 1'b0 && trans_cnt <= CNT_W'(CODE_W)));
    // R10
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |=> out_valid);
    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !code_valid |=> ($stable(bin_idx) && $stable(ones_cnt) && !out_valid));
endmodule

// File: tb/lbp_bin_encoder_tb_top.sv
module lbp_bin_encoder_tb_top;
    import lbp_bin_pkg::*;

    typedef struct packed {
        logic [7:0] code;
        logic [7:0] care;
        logic [7:0] want;
        logic [3:0] trans;
        logic [3:0] ones;
        logic [2:0] sym;
        logic       uni;
        logic [4:0] bin;
        logic       match;
    } vec_t;

    localparam int NVEC = 24;
    localparam vec_t VEC [NVEC] = '{
        '{8'hC3, 8'hFF, 8'hC3, 4'd2, 4'd4, 3'd4, 1'b1, 5'd14, 1'b1},
        '{8'h1C, 8'h1C, 8'h1C, 4'd2, 4'd3, 3'd3, 1'b1, 5'd2,  1'b1},
        '{8'h54, 8'h03, 8'h00, 4'd6, 4'd3, 3'd3, 1'b0, 5'd29, 1'b1},
        '{8'h6D, 8'h80, 8'h80, 4'd6, 4'd5, 3'd3, 1'b0, 5'd29, 1'b0},
        '{8'h00, 8'h00, 8'hFF, 4'd0, 4'd0, 3'd0, 1'b1, 5'd24, 1'b1},
        '{8'hFF, 8'h01, 8'h00, 4'd0, 4'd8, 3'd0, 1'b1, 5'd24, 1'b0},
        '{8'h01, 8'hFF, 8'h01, 4'd2, 4'd1, 3'd1, 1'b1, 5'd25, 1'b1},
        '{8'h81, 8'h81, 8'h80, 4'd2, 4'd2, 3'd2, 1'b1, 5'd26, 1'b0},
        '{8'h3F, 8'h00, 8'h00, 4'd2, 4'd6, 3'd2, 1'b1, 5'd27, 1'b1},
        '{8'h7F, 8'h00, 8'h00, 4'd2, 4'd7, 3'd1, 1'b1, 5'd28, 1'b1},
        '{8'h07, 8'h00, 8'h00, 4'd2, 4'd3, 3'd3, 1'b1, 5'd0,  1'b1},
        '{8'h83, 8'h00, 8'h00, 4'd2, 4'd3, 3'd3, 1'b1, 5'd7,  1'b1},
        '{8'h0F, 8'h00, 8'h00, 4'd2, 4'd4, 3'd4, 1'b1, 5'd8,  1'b1},
        '{8'h1F, 8'h00, 8'h00, 4'd2, 4'd5, 3'd3, 1'b1, 5'd16, 1'b1},
        '{8'hF8, 8'h00, 8'h00, 4'd2, 4'd5, 3'd3, 1'b1, 5'd19, 1'b1},
        '{8'hC1, 8'h00, 8'h00, 4'd2, 4'd3, 3'd3, 1'b1, 5'd6,  1'b1},
        '{8'hE1, 8'h00, 8'h00, 4'd2, 4'd4, 3'd4, 1'b1, 5'd13, 1'b1},
        '{8'hAA, 8'hF0, 8'hA0, 4'd8, 4'd4, 3'd4, 1'b0, 5'd29, 1'b1},
        '{8'h87, 8'h00, 8'h00, 4'd2, 4'd4, 3'd4, 1'b1, 5'd15, 1'b1},
        '{8'h9F, 8'h00, 8'h00, 4'd2, 4'd6, 3'd2, 1'b1, 5'd27, 1'b1},
        '{8'hF0, 8'h00, 8'h00, 4'd2, 4'd4, 3'd4, 1'b1, 5'd12, 1'b1},
        '{8'hE0, 8'h00, 8'h00, 4'd2, 4'd3, 3'd3, 1'b1, 5'd5,  1'b1},
        '{8'h8F, 8'h00, 8'h00, 4'd2, 4'd5, 3'd3, 1'b1, 5'd23, 1'b1},
        '{8'h05, 8'h0F, 8'h04, 4'd4, 4'd2, 3'd2, 1'b0, 5'd29, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        code_valid = 1'b0;
    logic [7:0]  code = '0;
    logic [7:0]  care_mask = '0;
    logic [7:0]  want_mask = '0;
    logic        out_valid;
    logic [3:0]  trans_cnt;
    logic [3:0]  ones_cnt;
    logic [2:0]  sym_lvl;
    logic        uniform;
    logic [4:0]  bin_idx;
    logic        match;
    logic [29:0] occ_vec;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    int hist [30];

    always #5 clk = ~clk;

    lbp_bin_encoder dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .code_valid (code_valid),
        .code       (code),
        .care_mask  (care_mask),
        .want_mask  (want_mask),
        .out_valid  (out_valid),
        .trans_cnt  (trans_cnt),
        .ones_cnt   (ones_cnt),
        .sym_lvl    (sym_lvl),
        .uniform    (uniform),
        .bin_idx    (bin_idx),
        .match      (match),
        .occ_vec    (occ_vec)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(out_valid == 1'b0, "R11 out_valid", out_valid, 0);
        chk(bin_idx == 0 && ones_cnt == 0 && trans_cnt == 0 && sym_lvl == 0 && !match && !uniform,
            "R11 outputs", {bin_idx, ones_cnt, trans_cnt}, 0);
        chk(occ_vec == '0, "R11 occ_vec", occ_vec, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10
        for (int v = 0; v < NVEC; v++) begin
            code = VEC[v].code;
            care_mask = VEC[v].care;
            want_mask = VEC[v].want;
            code_valid = 1'b1;
            @(negedge clk);
            chk(out_valid == 1'b1, "R10 out_valid", out_valid, 1);
            chk(trans_cnt == VEC[v].trans, "R1 trans_cnt", trans_cnt, VEC[v].trans);
            chk(uniform == VEC[v].uni, "R2 uniform", uniform, VEC[v].uni);
            chk(ones_cnt == VEC[v].ones, "R3 ones_cnt", ones_cnt, VEC[v].ones);
            chk(sym_lvl == VEC[v].sym, "R3 sym_lvl", sym_lvl, VEC[v].sym);
            chk(bin_idx == VEC[v].bin, "R4 R5 R6 bin_idx", bin_idx, VEC[v].bin);
            chk(occ_vec == (30'd1 << VEC[v].bin), "R7 occ_vec", occ_vec, 30'd1 << VEC[v].bin);
            chk(match == VEC[v].match, "R8 R9 match", match, VEC[v].match);
        end

        // R10: hold when idle; R7: occurrence vector clears
        code_valid = 1'b0;
        code = 8'h07;
        care_mask = 8'hFF;
        want_mask = 8'hFF;
        @(negedge clk);
        chk(out_valid == 1'b0, "R10 idle out_valid", out_valid, 0);
        chk(bin_idx == 5'd29 && ones_cnt == 4'd2 && match == 1'b0, "R10 hold",
            {bin_idx, ones_cnt, match}, {5'd29, 4'd2, 1'b0});
        chk(occ_vec == '0, "R7 idle occ_vec", occ_vec, 0);

        // R9: want ignored where care is zero
        code = 8'h0F;
        care_mask = 8'h0F;
        want_mask = 8'h5F;
        code_valid = 1'b1;
        @(negedge clk);
        chk(match == 1'b1, "R9 dont-care want", match, 1);
        // R8: a required one missing
        code = 8'h0E;
        @(negedge clk);
        chk(match == 1'b0, "R8 missing one", match, 0);

        // Full sweep of every code: bin population, R4 R5 R6 R7
        for (int b = 0; b < 30; b++) hist[b] = 0;
        care_mask = 8'h00;
        for (int c = 0; c < 256; c++) begin
            code = 8'(c);
            code_valid = 1'b1;
            @(negedge clk);
            if (out_valid && bin_idx < 30) hist[bin_idx]++;
            if (!(occ_vec[bin_idx] && $countones(occ_vec) == 1))
                chk(1'b0, "R7 sweep onehot", occ_vec, 30'd1 << bin_idx);
        end
        code_valid = 1'b0;
        for (int b = 0; b < 30; b++) begin
            int exp_n;
            exp_n = (b < 24) ? 1 : (b == 24) ? 2 : (b < 29) ? 8 : 198;
            chk(hist[b] == exp_n, (b < 24) ? "R4 bin count" : (b < 29) ? "R5 bin count" : "R6 bin count",
                hist[b], exp_n);
        end

        // R11: reset mid-run clears results
        code = 8'hC3;
        code_valid = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0 && bin_idx == 0 && ones_cnt == 0 && occ_vec == '0, "R11 mid-run reset",
            {out_valid, bin_idx, ones_cnt}, 0);
        rst_n = 1'b1;
        code_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule